// File: doc/BRIEF.md
# Break-Detecting Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. It watches a serial line, sampled on a 16x oversampling tick, and turns each character into a parallel byte in a holding register. The byte is flagged ready for the host, along with parity, framing and overrun status. Characters carry 5 to 8 data bits, least significant first, with an optional odd or even parity bit and one checked stop bit.

Two line conditions get special handling. First, a low that turns out to be a glitch at the half-bit check is dropped, and the search for a start bit resumes. Second, a line held low for a whole frame is a break. It is delivered as exactly one all-zero character with a framing error, and it raises a break indicator. The receiver then ignores the line until it has been seen high again.

The receiver runs only while it is enabled and the carrier-detect input is low. Dropping the carrier freezes the receiver where it is. Dropping the enable aborts the character in progress.

Top module: `async_rx_brk`

## Requirements
- R1: The receiver advances only on ticks that arrive while `rx_en` is 1 and `dcd_n` is 0. While `dcd_n` is 1, ticks are ignored and a partly received character resumes exactly where it stopped once `dcd_n` returns to 0.
- R2: A tick that sees the line low while the receiver is searching starts a candidate start bit. The line is sampled again 8 ticks later. If it is high then, nothing is stored and the search resumes.
- R3: After a valid start bit, the line is sampled every 16 ticks. The samples are the data bits (first sample lands in bit 0), then the parity bit if enabled, then one stop bit. The character is stored on the stop-bit sample.
- R4: `char_len` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Holding-register bits above the selected width read as 0.
- R5: A stop-bit sample of 0 sets `frm_err` for that character. If the line is still low on the next tick, that tick begins a new start bit.
- R6: If every sample of a frame is 0 (data, parity if enabled, and stop), one all-zero character is stored with `frm_err` set. No new start bit is accepted until a tick has seen the line high.
- R7: `brk_det` goes to 1 when a break character is stored. It returns to 0 on the first later tick that sees the line high.
- R8: Storing a character sets `rx_ready`. A one-cycle `rd_ack` pulse clears it. Storing while `rx_ready` is 1 and `rd_ack` is 0 sets `ovr_err`, which stays set until it is cleared.
- R9: With `par_en` = 1, the expected parity bit is the XOR of the data bits, inverted when `par_odd` = 1. `par_err` is set when the received bit differs from it. `par_err` and `frm_err` are rewritten on every store.
- R10: A one-cycle `err_clr` pulse clears `par_err`, `frm_err` and `ovr_err`. With `rx_en` = 0, the following are all cleared: the three error flags, `rx_ready`, `brk_det`, and any partial character. After re-enabling, the line must be seen high before a start bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, high is mark |
| rx_en | input | 1 | Receiver enable |
| dcd_n | input | 1 | Carrier detect, active low |
| char_len | input | 2 | Data width code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_ack | input | 1 | Host has read the holding register |
| err_clr | input | 1 | Clear the error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register has an unread character |
| par_err | output | 1 | Parity error on the last character |
| frm_err | output | 1 | Stop bit missing on the last character |
| ovr_err | output | 1 | A character overwrote an unread one |
| brk_det | output | 1 | Line break seen, waiting for mark |

## Verification
The hardest case to reach is a missing stop bit whose low level runs on into a new start bit. The new start is found one tick after the stop sample, which is out of phase with the sender's bit grid. The stimulus reaches it by sending a frame with a low stop bit and then, with no idle gap, a second complete frame. The bench model must then recover the second byte, clear the framing flag and raise overrun.

Freezing the receiver in mid-character is reached by raising carrier-detect between two data bits and toggling the line during the pause. A break is produced by holding the line low for many frame times.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        ST_MARK,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
        logic          brk;
    } rx_char_t;

    function automatic logic [3:0] len_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [DW-1:0] align_lsb(input logic [DW-1:0] sh, input logic [1:0] code);
        return sh >> (2'd3 - code);
    endfunction

    function automatic logic exp_parity(input logic [DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/rx_line_fsm.sv
module rx_line_fsm
    import rxb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tk,
    input  logic       rxd,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       store,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [3:0]    nbit;
    logic [DW-1:0] shreg;
    logic          pbit;
    logic          at_half, at_full;

    assign at_half = (cnt == HALF_M1);
    assign at_full = (cnt == FULL_M1);
    assign store   = tk && (state == ST_STOP) && at_full;

    always_comb begin
        chr.data = align_lsb(shreg, len);
        chr.perr = par_en && (pbit != exp_parity(chr.data, par_odd));
        chr.ferr = !rxd;
        chr.brk  = !rxd && (shreg == '0) && !(par_en && pbit);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= ST_MARK;
            cnt   <= '0;
            nbit  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (tk) begin
            case (state)
                ST_MARK: if (rxd) state <= ST_IDLE;
                ST_IDLE: if (!rxd) begin
                    state <= ST_START;
                    cnt   <= '0;
                end
                ST_START: if (at_half) begin
                    state <= rxd ? ST_IDLE : ST_DATA;
                    cnt   <= '0;
                    nbit  <= '0;
                    shreg <= '0;
                end else cnt <= cnt + 1'b1;
                ST_DATA: if (at_full) begin
                    cnt   <= '0;
                    shreg <= {rxd, shreg[DW-1:1]};
                    nbit  <= nbit + 4'd1;
                    if (nbit + 4'd1 == len_bits(len))
                        state <= par_en ? ST_PAR : ST_STOP;
                end else cnt <= cnt + 1'b1;
                ST_PAR: if (at_full) begin
                    cnt   <= '0;
                    pbit  <= rxd;
                    state <= ST_STOP;
                end else cnt <= cnt + 1'b1;
                ST_STOP: if (at_full) begin
                    cnt   <= '0;
                    state <= chr.brk ? ST_MARK : ST_IDLE;
                end else cnt <= cnt + 1'b1;
                default: state <= ST_MARK;
            endcase
        end
    end

    // R1: without a qualified tick the receiver does not move
    a_r1_frozen_without_tick: assert property (@(posedge clk) disable iff (rst)
        (en && !tk) |=> ($stable(state) && $stable(cnt) && $stable(shreg)));

    // R6: after a break the receiver waits for mark
    a_r6_break_waits_mark: assert property (@(posedge clk) disable iff (rst)
        (en && store && chr.brk) |=> (state == ST_MARK));

    // R2: a high line at the half-bit check abandons the candidate
    a_r2_false_start_drops: assert property (@(posedge clk) disable iff (rst)
        (en && tk && state == ST_START && at_half && rxd) |=> (state == ST_IDLE));

endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
    import rxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          store,
    input  rx_char_t      chr,
    input  logic          rd_ack,
    input  logic          err_clr,
    output logic [DW-1:0] data,
    output logic          ready,
    output logic          perr,
    output logic          ferr,
    output logic          oerr
);
    always_ff @(posedge clk) begin
        if (rst) data <= '0;
        else if (en && store) data <= chr.data;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            oerr  <= 1'b0;
        end else if (store) begin
            ready <= 1'b1;
            perr  <= chr.perr;
            ferr  <= chr.ferr;
            oerr  <= (ready && !rd_ack) || (oerr && !err_clr);
        end else begin
            if (rd_ack) ready <= 1'b0;
            if (err_clr) begin
                perr <= 1'b0;
                ferr <= 1'b0;
                oerr <= 1'b0;
            end
        end
    end

    a_r8_ready_on_store: assert property (@(posedge clk) disable iff (rst)
        (en && store) |=> ready);

    a_r8_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (en && rd_ack && !store) |=> !ready);

    a_r8_overrun_flagged: assert property (@(posedge clk) disable iff (rst)
        (en && store && ready && !rd_ack) |=> oerr);

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ready && !perr && !ferr && !oerr));

    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        (en && err_clr && !store) |=> (!perr && !ferr && !oerr));

endmodule

// File: rtl/rx_break_flag.sv
module rx_break_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set,
    input  logic tk,
    input  logic rxd,
    output logic brk_o
);
    always_ff @(posedge clk) begin
        if (rst || !en)      brk_o <= 1'b0;
        else if (set)        brk_o <= 1'b1;
        else if (tk && rxd)  brk_o <= 1'b0;
    end

    // R7: indicator persists until a tick sees mark
    a_r7_held_until_mark: assert property (@(posedge clk) disable iff (rst)
        (en && brk_o && !(tk && rxd)) |=> brk_o);

    a_r7_clears_on_mark: assert property (@(posedge clk) disable iff (rst)
        (en && brk_o && !set && tk && rxd) |=> !brk_o);

endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk
    import rxb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       dcd_n,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_ack,
    input  logic       err_clr,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       par_err,
    output logic       frm_err,
    output logic       ovr_err,
    output logic       brk_det
);
    logic     tk;
    logic     store;
    rx_char_t chr;

    assign tk = tick16 && rx_en && !dcd_n;

    rx_line_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst(rst), .en(rx_en), .tk(tk), .rxd(rxd),
        .len(char_len), .par_en(par_en), .par_odd(par_odd),
        .store(store), .chr(chr)
    );

    rx_hold_regs u_hold (
        .clk(clk), .rst(rst), .en(rx_en), .store(store), .chr(chr),
        .rd_ack(rd_ack), .err_clr(err_clr),
        .data(rx_data), .ready(rx_ready), .perr(par_err),
        .ferr(frm_err), .oerr(ovr_err)
    );

    rx_break_flag u_brk (
        .clk(clk), .rst(rst), .en(rx_en), .set(store && chr.brk),
        .tk(tk), .rxd(rxd), .brk_o(brk_det)
    );

endmodule

// File: tb/tb_async_rx_brk.sv
`timescale 1ns/1ps
module tb_async_rx_brk;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16;
    logic rxd = 1'b1, rx_en = 1'b0, dcd_n = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic par_en = 1'b0, par_odd = 1'b0, rd_ack = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic rx_ready, par_err, frm_err, ovr_err, brk_det;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    assign tick16 = (tdiv == 0);

    async_rx_brk dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .dcd_n(dcd_n), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
    );

    // behavioural reference: 0 wait mark, 1 search, 2 start check, 3 collecting samples
    int   m_mode = 0, m_cnt = 0;
    bit   m_bits[$];
    int   m_data = 0;
    bit   m_ready = 0, m_pe = 0, m_fe = 0, m_oe = 0, m_brk = 0;

    always @(posedge clk) begin
        bit stored, s_pe, s_fe, s_brk;
        int s_data, need, nb, ones;
        stored = 0; s_pe = 0; s_fe = 0; s_brk = 0; s_data = 0;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_bits.delete(); m_data = 0;
            m_ready = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_brk = 0;
        end else if (!rx_en) begin
            m_mode = 0; m_cnt = 0; m_bits.delete();
            m_ready = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_brk = 0;
        end else begin
            if (tick16 && !dcd_n) begin
                nb = 5 + int'(char_len);
                need = nb + (par_en ? 1 : 0) + 1;
                if (m_mode == 0) begin
                    if (rxd) begin m_mode = 1; m_brk = 0; end
                end else if (m_mode == 1) begin
                    if (!rxd) begin m_mode = 2; m_cnt = 0; end
                end else if (m_mode == 2) begin
                    m_cnt++;
                    if (m_cnt == 8) begin
                        if (rxd) m_mode = 1;
                        else begin m_mode = 3; m_cnt = 0; m_bits.delete(); end
                    end
                end else begin
                    m_cnt++;
                    if (m_cnt == 16) begin
                        m_cnt = 0;
                        m_bits.push_back(rxd);
                        if (m_bits.size() == need) begin
                            ones = 0;
                            for (int i = 0; i < nb; i++) begin
                                if (m_bits[i]) begin s_data += (1 << i); ones++; end
                            end
                            if (par_en) s_pe = (m_bits[nb] != ((ones % 2 == 1) ^ par_odd));
                            s_fe = !m_bits[need-1];
                            s_brk = 1;
                            foreach (m_bits[k]) if (m_bits[k]) s_brk = 0;
                            stored = 1;
                            m_mode = s_brk ? 0 : 1;
                            if (s_brk) m_brk = 1;
                            m_bits.delete();
                        end
                    end
                end
            end
            if (stored) begin
                m_oe = (m_ready && !rd_ack) || (m_oe && !err_clr);
                m_data = s_data; m_ready = 1; m_pe = s_pe; m_fe = s_fe;
            end else begin
                if (rd_ack) m_ready = 0;
                if (err_clr) begin m_pe = 0; m_fe = 0; m_oe = 0; end
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R4", "rx_data vs model", int'(rx_data), m_data);
            chk("R8", "rx_ready vs model", int'(rx_ready), int'(m_ready));
            chk("R9", "par_err vs model", int'(par_err), int'(m_pe));
            chk("R5", "frm_err vs model", int'(frm_err), int'(m_fe));
            chk("R8", "ovr_err vs model", int'(ovr_err), int'(m_oe));
            chk("R7", "brk_det vs model", int'(brk_det), int'(m_brk));
        end
    end

    task automatic ticks(input logic v, input int n);
        rxd = v;
        repeat (n) begin
            do @(posedge clk); while (!tick16);
        end
        @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input int nb, input bit pen,
                         input logic pb, input logic stp);
        ticks(1'b0, 16);
        for (int i = 0; i < nb; i++) ticks(d[i], 16);
        if (pen) ticks(pb, 16);
        ticks(stp, 16);
    endtask

    task automatic host_read();
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    endtask

    task automatic clear_errs();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "ready after reset", int'(rx_ready), 0);
        chk("R7", "break after reset", int'(brk_det), 0);
        // R1: disabled receiver ignores a frame
        frame(8'h33, 8, 0, 1'b0, 1'b1);
        chk("R1", "ready while disabled", int'(rx_ready), 0);
        rx_en = 1'b1;
        ticks(1'b1, 20);
        // R3: 8-bit character, LSB first
        frame(8'hA5, 8, 0, 1'b0, 1'b1);
        chk("R3", "8-bit data", int'(rx_data), 8'hA5);
        chk("R8", "ready after store", int'(rx_ready), 1);
        host_read();
        chk("R8", "ready after read", int'(rx_ready), 0);
        // R4: 5-bit even parity, upper bits zero (0x16 has three ones, parity bit 1)
        char_len = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        frame(8'hF6, 5, 1, 1'b1, 1'b1);
        chk("R4", "5-bit upper zero", int'(rx_data), 8'h16);
        chk("R9", "even parity ok", int'(par_err), 0);
        host_read();
        // R9: 7-bit odd parity: 0x35 has four ones so bit is 1
        char_len = 2'd2; par_odd = 1'b1;
        frame(8'h35, 7, 1, 1'b1, 1'b1);
        chk("R9", "odd parity ok", int'(par_err), 0);
        host_read();
        frame(8'h35, 7, 1, 1'b0, 1'b1);
        chk("R9", "odd parity wrong bit", int'(par_err), 1);
        host_read();
        clear_errs();
        chk("R10", "err_clr clears parity", int'(par_err), 0);
        // R4: 6-bit, no parity
        char_len = 2'd1; par_en = 1'b0;
        frame(8'hED, 6, 0, 1'b0, 1'b1);
        chk("R4", "6-bit data", int'(rx_data), 8'h2D);
        host_read();
        // R2: short low pulse is rejected
        char_len = 2'd3;
        ticks(1'b0, 5);
        ticks(1'b1, 40);
        chk("R2", "false start stores nothing", int'(rx_ready), 0);
        chk("R2", "false start keeps data", int'(rx_data), 8'h2D);
        // R5: missing stop bit, then idle
        frame(8'h3C, 8, 0, 1'b0, 1'b0);
        ticks(1'b1, 40);
        chk("R5", "framing error set", int'(frm_err), 1);
        chk("R5", "framing data", int'(rx_data), 8'h3C);
        host_read();
        clear_errs();
        // R5: low stop bit running into the next frame
        frame(8'h81, 8, 0, 1'b0, 1'b0);
        ticks(1'b0, 16);
        for (int i = 0; i < 8; i++) ticks(8'h7E >> i, 16);
        ticks(1'b1, 40);
        chk("R5", "continued start data", int'(rx_data), 8'h7E);
        chk("R5", "continued start no frm_err", int'(frm_err), 0);
        chk("R8", "overrun on unread", int'(ovr_err), 1);
        host_read();
        clear_errs();
        chk("R10", "err_clr clears overrun", int'(ovr_err), 0);
        // R6/R7: long break
        ticks(1'b0, 200);
        chk("R6", "break char zero", int'(rx_data), 0);
        chk("R6", "break frm_err", int'(frm_err), 1);
        chk("R7", "break_det high", int'(brk_det), 1);
        host_read();
        ticks(1'b0, 60);
        chk("R6", "single break char", int'(rx_ready), 0);
        chk("R7", "break_det held", int'(brk_det), 1);
        ticks(1'b1, 2);
        chk("R7", "break_det cleared at mark", int'(brk_det), 0);
        ticks(1'b1, 20);
        clear_errs();
        // R1: carrier loss pauses a character
        ticks(1'b0, 16);
        ticks(1'b1, 16);
        dcd_n = 1'b1;
        ticks(1'b0, 30);
        ticks(1'b1, 7);
        rxd = 1'b0;
        dcd_n = 1'b0;
        for (int i = 1; i < 8; i++) ticks(8'h55 >> i, 16);
        ticks(1'b1, 30);
        chk("R1", "paused char intact", int'(rx_data), 8'h55);
        host_read();
        // R10: disable aborts partial char
        ticks(1'b0, 16);
        ticks(1'b1, 32);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R10", "disable clears ready", int'(rx_ready), 0);
        ticks(1'b1, 5);
        rx_en = 1'b1;
        ticks(1'b1, 20);
        frame(8'h5A, 8, 0, 1'b0, 1'b1);
        chk("R10", "fresh char after re-enable", int'(rx_data), 8'h5A);
        chk("R10", "no overrun after re-enable", int'(ovr_err), 0);
        ticks(1'b1, 10);
        finish_run();
    end
endmodule